// File: doc/BRIEF.md
# Strobe-Captured 256x4 Static Memory

This block is a 256-word by 4-bit static memory whose address is taken from the address bus only at the start of an access. The start is marked by the active-low enable strobe going low. The block runs on a system clock and samples the strobe, the write control and the two selects on its rising edge. The first edge that sees the strobe low, after an edge that saw it high, copies all eight address bits into a holding register. From then until the strobe returns high, the address bus may carry anything without effect. This lets a processor multiplex its address bus or move on to the next address early.

The captured address is split into a 5-bit row index and a 3-bit column-group index. These select one 4-bit word in a 32-by-32 bit cell array. Data in and data out share one 4-bit bidirectional bus.

During a read, an output register loads the addressed word on every edge while the read conditions hold, and keeps its last value once they stop. Three-state drivers put that value on the bus. The drivers are released at once whenever the access stops being a selected read. Two active-low selects must both be asserted, so that several devices can share the bus in a wider or deeper array. The cell contents have no reset and need no refresh.

Top module: `sram_latched_256x4`

## Requirements
- R1: After a write of value v to address a, every later read of a returns v until a is written again. All 256 addresses hold independent values.
- R2: The address is captured on the first rising edge at which `en_n` is sampled low after being sampled high. Changes on `addr` after that edge do not change which word is read or written in that access.
- R3: Address bits 7, 6, 5, 1 and 0 select the row, and bits 4, 3 and 2 select one of eight 4-bit groups in that row. Each address maps to its own cell group, so no two addresses alias.
- R4: A write stores the value on `dq` at the captured address on each rising edge after the capture edge at which `en_n`, `wr_n`, `cs_a_n` and `cs_b_n` are all low. The block does not drive `dq` while `wr_n` is low.
- R5: In a read access (`wr_n` high, both selects low), the word at the captured address is on `dq` after the second rising edge that sees `en_n` low, counting the capture edge as the first.
- R6: `dq` is released, without waiting for a clock edge, whenever `en_n` is high, either select is high, or `wr_n` is low.
- R7: A write attempt while either select is high leaves the memory unchanged.
- R8: A write attempt while `en_n` is high leaves the memory unchanged.
- R9: `rst_n` low clears only the access control: the bus is released and stored words keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | 8 | Word address, captured at the start of an access |
| en_n | input | 1 | Active-low enable strobe; its falling edge starts an access |
| wr_n | input | 1 | Active-low write control |
| cs_a_n | input | 1 | First active-low select |
| cs_b_n | input | 1 | Second active-low select |
| dq | inout | 4 | Shared data bus: write data in, read data out |

## Verification
The capture takes effect at the first rising edge that samples `en_n` low. Read data reaches the bus one edge later, and a write lands in the array on that same second edge. Release of the bus is combinational, so it is due in the same cycle as the input change. The bench drives every input at the falling clock edge. It samples a read 1 ns after the falling edge that follows the second rising edge of the access, by which point both registers on the path have loaded. Release is checked a fraction of a nanosecond after the input that causes it, with no clock edge in between. To catch a driver that stays on, the bench drives a probe value onto the bus that differs from the held read word.

// File: rtl/sram_lat_pkg.sv
package sram_lat_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 4;
  localparam int ROW_W  = 5;
  localparam int GRP_W  = 3;

  // Row index gathered from the outer address bits: {a7,a6,a5,a1,a0}
  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return {a[7], a[6], a[5], a[1], a[0]};
  endfunction

  // Column group index from the middle address bits: {a4,a3,a2}
  function automatic logic [GRP_W-1:0] grp_of(input logic [ADDR_W-1:0] a);
    return a[4:2];
  endfunction

endpackage

// File: rtl/sram_lat_ctl.sv
module sram_lat_ctl #(
  parameter int AW = sram_lat_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          en_n,
  input  logic          wr_n,
  input  logic          cs_a_n,
  input  logic          cs_b_n,
  output logic [AW-1:0] addr_lat,
  output logic          fall_evt,
  output logic          cyc_live,
  output logic          wr_pulse,
  output logic          rd_load
);

  logic          en_n_d;
  logic          armed;
  logic [AW-1:0] addr_q;
  logic          sel_ok;

  assign sel_ok   = ~cs_a_n & ~cs_b_n;
  // strobe seen high on the previous edge and low on this one
  assign fall_evt = en_n_d & ~en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_n_d <= 1'b1;
      armed  <= 1'b0;
      addr_q <= '0;
    end else begin
      en_n_d <= en_n;
      if (fall_evt) begin
        addr_q <= addr;
      end
      if (en_n) begin
        armed <= 1'b0;
      end else if (fall_evt) begin
        armed <= 1'b1;
      end
    end
  end

  assign addr_lat = addr_q;
  assign cyc_live = armed & ~en_n;
  assign wr_pulse = cyc_live & sel_ok & ~wr_n;
  assign rd_load  = cyc_live & sel_ok & wr_n;

endmodule

// File: rtl/sram_lat_decode.sv
module sram_lat_decode #(
  parameter int AW    = sram_lat_pkg::ADDR_W,
  parameter int ROW_W = sram_lat_pkg::ROW_W,
  parameter int GRP_W = sram_lat_pkg::GRP_W
) (
  input  logic [AW-1:0]           addr_lat,
  output logic [(1<<ROW_W)-1:0]   row_sel,
  output logic [(1<<GRP_W)-1:0]   grp_sel
);

  localparam int ROWS = 1 << ROW_W;
  localparam int GRPS = 1 << GRP_W;

  logic [ROW_W-1:0] r_idx;
  logic [GRP_W-1:0] g_idx;

  assign r_idx = sram_lat_pkg::row_of(addr_lat);
  assign g_idx = sram_lat_pkg::grp_of(addr_lat);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = (r_idx == ROW_W'(r));
  end

  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    assign grp_sel[g] = (g_idx == GRP_W'(g));
  end

endmodule

// File: rtl/sram_lat_array.sv
module sram_lat_array #(
  parameter int DW    = sram_lat_pkg::DATA_W,
  parameter int ROW_W = sram_lat_pkg::ROW_W,
  parameter int GRP_W = sram_lat_pkg::GRP_W
) (
  input  logic                    clk,
  input  logic [(1<<ROW_W)-1:0]   row_sel,
  input  logic [(1<<GRP_W)-1:0]   grp_sel,
  input  logic                    wr_pulse,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata
);

  localparam int ROWS   = 1 << ROW_W;
  localparam int GRPS   = 1 << GRP_W;
  localparam int LINE_W = GRPS * DW;

  logic [LINE_W-1:0] row_q [ROWS];
  logic [LINE_W-1:0] line_sel;

  for (genvar r = 0; r < ROWS; r++) begin : g_line
    logic [LINE_W-1:0] cells;
    always_ff @(posedge clk) begin
      if (wr_pulse && row_sel[r]) begin
        for (int g = 0; g < GRPS; g++) begin
          if (grp_sel[g]) begin
            cells[g*DW +: DW] <= wdata;
          end
        end
      end
    end
    assign row_q[r] = cells;
  end

  // one-hot AND-OR selection of the row, then of the group
  always_comb begin
    line_sel = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_sel[r]) begin
        line_sel = line_sel | row_q[r];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < GRPS; g++) begin
      if (grp_sel[g]) begin
        rdata = rdata | line_sel[g*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/sram_lat_out.sv
module sram_lat_out #(
  parameter int DW = sram_lat_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_load,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dout,
  output logic          bus_oe
);

  logic [DW-1:0] dout_q;
  logic          oe_q;

  // follows the array while loading, keeps the last word afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= rd_load;
      if (rd_load) begin
        dout_q <= rdata;
      end
    end
  end

  assign dout   = dout_q;
  // turn-on waits for a loaded word; turn-off follows the inputs at once
  assign bus_oe = oe_q & rd_load;

endmodule

// File: rtl/sram_latched_256x4.sv
module sram_latched_256x4 #(
  parameter int DW    = sram_lat_pkg::DATA_W,
  parameter int ROW_W = sram_lat_pkg::ROW_W,
  parameter int GRP_W = sram_lat_pkg::GRP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROW_W+GRP_W-1:0]   addr,
  input  logic                     en_n,
  input  logic                     wr_n,
  input  logic                     cs_a_n,
  input  logic                     cs_b_n,
  inout  wire  [DW-1:0]            dq
);

  localparam int AW   = ROW_W + GRP_W;
  localparam int ROWS = 1 << ROW_W;
  localparam int GRPS = 1 << GRP_W;

  logic [AW-1:0]   addr_lat;
  logic            fall_evt;
  logic            cyc_live;
  logic            wr_pulse;
  logic            rd_load;
  logic [ROWS-1:0] row_sel;
  logic [GRPS-1:0] grp_sel;
  logic [DW-1:0]   rdata;
  logic [DW-1:0]   dout;
  logic            bus_oe;

  sram_lat_ctl #(.AW(AW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .en_n     (en_n),
    .wr_n     (wr_n),
    .cs_a_n   (cs_a_n),
    .cs_b_n   (cs_b_n),
    .addr_lat (addr_lat),
    .fall_evt (fall_evt),
    .cyc_live (cyc_live),
    .wr_pulse (wr_pulse),
    .rd_load  (rd_load)
  );

  sram_lat_decode #(.AW(AW), .ROW_W(ROW_W), .GRP_W(GRP_W)) u_dec (
    .addr_lat (addr_lat),
    .row_sel  (row_sel),
    .grp_sel  (grp_sel)
  );

  sram_lat_array #(.DW(DW), .ROW_W(ROW_W), .GRP_W(GRP_W)) u_arr (
    .clk      (clk),
    .row_sel  (row_sel),
    .grp_sel  (grp_sel),
    .wr_pulse (wr_pulse),
    .wdata    (dq),
    .rdata    (rdata)
  );

  sram_lat_out #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_load (rd_load),
    .rdata   (rdata),
    .dout    (dout),
    .bus_oe  (bus_oe)
  );

  assign dq = bus_oe ? dout : {DW{1'bz}};

endmodule

// File: rtl/sram_lat_chk.sv
module sram_lat_chk #(
  parameter int AW   = 8,
  parameter int ROWS = 32,
  parameter int GRPS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_n,
  input logic [AW-1:0]   addr_lat,
  input logic            fall_evt,
  input logic            cyc_live,
  input logic            wr_pulse,
  input logic            rd_load,
  input logic [ROWS-1:0] row_sel,
  input logic [GRPS-1:0] grp_sel,
  input logic            bus_oe
);

  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_live |=> $stable(addr_lat));

  a_r2_capture_arms: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (cyc_live || en_n));

  a_r3_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);

  a_r3_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grp_sel) == 1);

  a_r4_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !bus_oe);

  a_r5_drive_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(rd_load));

  a_r5_not_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> !bus_oe);

  a_r6_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> !bus_oe);

  a_r8_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> !wr_pulse);

endmodule

bind sram_latched_256x4 sram_lat_chk #(.AW(AW), .ROWS(ROWS), .GRPS(GRPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_n     (en_n),
  .addr_lat (addr_lat),
  .fall_evt (fall_evt),
  .cyc_live (cyc_live),
  .wr_pulse (wr_pulse),
  .rd_load  (rd_load),
  .row_sel  (row_sel),
  .grp_sel  (grp_sel),
  .bus_oe   (bus_oe)
);

// File: tb/test_sram_latched_256x4.sv
`timescale 1ns/10ps
module test_sram_latched_256x4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic       en_n, wr_n, cs_a_n, cs_b_n;
  logic       tb_oe;
  logic [3:0] tb_d;
  wire  [3:0] dq;

  assign dq = tb_oe ? tb_d : 4'bzzzz;

  always #2 clk = ~clk;  // 250 MHz

  sram_latched_256x4 i_sram_latched_256x4 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_n(en_n), .wr_n(wr_n),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .dq(dq)
  );

  typedef struct { logic [3:0] val; string tag; } exp_t;
  exp_t       exp_q[$];
  event       smp_ev;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;
  logic [3:0] ref_mem [256];

  // monitor: pops one expected item per sample request
  initial begin
    forever begin
      exp_t it;
      @(smp_ev);
      it = exp_q.pop_front();
      n_chk++;
      if (dq !== it.val) begin
        n_fail++;
        $display("FAIL %s: dq=%h expected %h", it.tag, dq, it.val);
      end
    end
  end

  task automatic smp(input logic [3:0] v, input string tag);
    exp_q.push_back('{v, tag});
    -> smp_ev;
    #0.1;
  endtask

  task automatic idle_bus();
    en_n = 1'b1; wr_n = 1'b1; cs_a_n = 1'b0; cs_b_n = 1'b0; tb_oe = 1'b0;
  endtask

  // write access; updates the reference only when a store is due
  task automatic wr(input logic [7:0] a, input logic [3:0] d,
                    input bit sa, input bit sb, input bit en_lo);
    @(negedge clk);
    addr = a; en_n = ~en_lo; wr_n = 1'b0; cs_a_n = sa; cs_b_n = sb;
    tb_oe = 1'b1; tb_d = d;
    @(negedge clk);       // capture edge has passed
    addr = ~a;            // R2: later address changes are ignored
    @(negedge clk);       // store edge has passed
    if (en_lo && !sa && !sb) ref_mem[a] = d;
    idle_bus();
  endtask

  // read access; mode 0 plain, 1 select drop, 2 strobe rise, 3 write turn
  task automatic rd(input logic [7:0] a, input int mode, input string tag);
    logic [3:0] probe;
    @(negedge clk);
    addr = a; en_n = 1'b0; wr_n = 1'b1; cs_a_n = 1'b0; cs_b_n = 1'b0; tb_oe = 1'b0;
    @(negedge clk);
    addr = ~a;
    @(negedge clk);
    #1 smp(ref_mem[a], tag);
    probe = ~ref_mem[a];
    if (mode != 0) begin
      tb_d = probe; tb_oe = 1'b1;
      case (mode)
        1: cs_b_n = 1'b1;
        2: en_n = 1'b1;
        default: wr_n = 1'b0;
      endcase
      #0.3 smp(probe, "R6 release");
      if (mode == 3) begin
        @(negedge clk);   // store edge at the captured address (R4, R2)
        ref_mem[a] = probe;
      end
    end
    @(negedge clk);
    idle_bus();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; tb_d = 4'h9;
    idle_bus();
    tb_oe = 1'b1;
    repeat (3) @(negedge clk);
    #1 smp(4'h9, "R9 reset releases bus");
    tb_oe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3: every address, with values that differ across any one-bit address change
    for (int a = 0; a < 256; a++) begin
      logic [7:0] av;
      av = 8'(a);
      wr(av, av[3:0] ^ av[7:4], 1'b0, 1'b0, 1'b1);
    end
    for (int a = 0; a < 256; a++) rd(8'(a), 0, "R1 R3 sweep read");

    // R1: overwrite and read back
    wr(8'h5A, 4'hC, 1'b0, 1'b0, 1'b1);
    rd(8'h5A, 0, "R1 overwrite");

    // R5 R6: release on select drop, on strobe rise
    wr(8'h21, 4'h6, 1'b0, 1'b0, 1'b1);
    rd(8'h21, 1, "R5 read before select drop");
    rd(8'h21, 2, "R5 read before strobe rise");
    rd(8'h21, 0, "R7 unchanged after select drop");

    // R4 R6: turning the access into a write releases the bus and stores at captured address
    rd(8'h42, 3, "R5 read before write turn");
    rd(8'h42, 0, "R4 stored at captured address");
    rd(8'hBD, 0, "R2 scrambled address untouched");

    // R7: write attempts with a select high
    wr(8'h10, 4'h7, 1'b0, 1'b0, 1'b1);
    wr(8'h10, 4'h8, 1'b1, 1'b0, 1'b1);
    rd(8'h10, 0, "R7 first select high");
    wr(8'h10, 4'h8, 1'b0, 1'b1, 1'b1);
    rd(8'h10, 0, "R7 second select high");

    // R8: write attempt with the strobe high
    wr(8'h10, 4'hE, 1'b0, 1'b0, 1'b0);
    rd(8'h10, 0, "R8 strobe high no store");

    // R9: reset keeps contents
    wr(8'h3C, 4'hB, 1'b0, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'h3C, 0, "R9 contents kept over reset");

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule